// File: doc/BRIEF.md
# Circular Status Queue Writer

This block keeps a 64-word circular log in shared RAM through which a bus-control sequencer hands values to a host processor. The sequencer offers one value at a time on a valid/ready push port. A push can carry an immediate value, the block status word of the last message, the current time tag, or an indirect request that names a RAM address. For an indirect request the block first reads that address and then logs the word it read. Each logged word goes to the slot named by a queue pointer. The pointer then advances and wraps from the last slot of its 64-word window back to the first slot.

The host can read the pointer at any time and can overwrite it. Overwriting the pointer relocates the queue. The window base is always the pointer with its low six bits cleared, so a relocated queue sits on a 64-word boundary. When the wrap interrupt is enabled, each rollover gives a one-cycle interrupt pulse.

Back-pressure rules: a push is accepted on a rising clock edge where `push_valid` and `push_ready` are both high. The sequencer must hold `push_src` and `push_data` stable while `push_valid` is high and not yet accepted. Direct pushes complete in the cycle they are accepted, so `push_ready` stays high. An indirect push holds `push_ready` low for exactly one cycle after acceptance. The RAM port has no handshake and returns read data one cycle after a read.

Top module: `sqw_queue_writer`

## Requirements
- R1: An accepted push writes one word at the current pointer address. `push_src` selects the value written: 0 writes `push_data`, 1 writes `bsw_in`, 2 writes `ttag_in`, and 3 writes the RAM word at address `push_data`.
- R2: After reset, `q_ptr` is 0x00C0, `push_ready` is high and `wrap_irq` is low.
- R3: Each logged word advances the pointer by one within its 64-word window.
- R4: A write at the last slot of the window (low six bits all ones) returns the pointer to the window base. The base is the pointer with its low six bits cleared. After 64 writes the pointer is back where it started.
- R5: `wrap_irq` pulses high for exactly one cycle, in the cycle after a wrapping write, and only when `wrap_irq_en` is high.
- R6: An indirect push makes a RAM read of `push_data` in its acceptance cycle. It writes the word read in the next cycle, with `push_ready` low in that cycle. Direct pushes keep `push_ready` high.
- R7: A host pointer write (`ptr_wr_en`) loads `ptr_wr_data` into `q_ptr` at the next edge. The following pushes fill the relocated window.
- R8: If a host pointer write and a logged word fall in the same cycle, the word is still stored at the old pointer. The pointer takes the host value, and no wrap pulse follows.
- R9: With no push in progress, the RAM port stays idle (`mem_en` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push request from the sequencer |
| push_ready | output | 1 | Block can accept a push |
| push_src | input | 2 | Source select: 0 immediate, 1 block status, 2 time tag, 3 indirect |
| push_data | input | 16 | Immediate value or indirect address |
| bsw_in | input | 16 | Block status word of the last message |
| ttag_in | input | 16 | Current time tag value |
| ptr_wr_en | input | 1 | Host pointer write strobe |
| ptr_wr_data | input | 16 | New pointer value from the host |
| q_ptr | output | 16 | Queue pointer (next slot to be written) |
| wrap_irq_en | input | 1 | Enable for the wrap interrupt |
| wrap_irq | output | 1 | One-cycle wrap interrupt pulse |
| mem_en | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write (1) or read (0) |
| mem_addr | output | 16 | RAM address |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, one cycle after a read |

## Verification
The hardest case to reach is a wrap at the same time as other activity. This covers the last-slot write that triggers the interrupt, a wrap reached through a full 64-push lap, and a host pointer write landing in the same cycle as a logged word. The bench reaches these states by first loading the pointer with a host write to one or two slots before the window end. It then issues single pushes with the interrupt enable on, and with it off. It also drives the host strobe and a push at the same falling edge, so both are taken at one rising edge. Indirect pushes are checked in the middle of the transfer, which shows that ready is low during the write-back cycle.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
  typedef enum logic [1:0] {
    SRC_IMM  = 2'd0,
    SRC_BSW  = 2'd1,
    SRC_TTAG = 2'd2,
    SRC_IND  = 2'd3
  } sqw_src_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WBACK = 1'b1
  } sqw_state_e;
endpackage

// File: rtl/sqw_value_sel.sv
module sqw_value_sel #(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        src,
  input  logic [DATA_W-1:0] imm,
  input  logic [DATA_W-1:0] bsw,
  input  logic [DATA_W-1:0] ttag,
  output logic [DATA_W-1:0] value
);
  import sqw_pkg::*;

  always_comb begin
    unique case (sqw_src_e'(src))
      SRC_BSW:  value = bsw;
      SRC_TTAG: value = ttag;
      default:  value = imm;
    endcase
  end
endmodule

// File: rtl/sqw_ptr.sv
module sqw_ptr #(
  parameter int              ADDR_W    = 16,
  parameter int              SLOT_W    = 6,
  parameter logic [ADDR_W-1:0] RESET_PTR = 16'h00C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_data,
  output logic [ADDR_W-1:0] ptr,
  output logic              wrap
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = '1;
  localparam logic [SLOT_W-1:0] ONE_SLOT  = {{(SLOT_W-1){1'b0}}, 1'b1};

  logic [SLOT_W-1:0] slot_nxt;

  assign slot_nxt = ptr[SLOT_W-1:0] + ONE_SLOT;
  assign wrap     = advance && !host_wr && (ptr[SLOT_W-1:0] == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= RESET_PTR;
    else if (host_wr)
      ptr <= host_data;
    else if (advance)
      ptr <= {ptr[ADDR_W-1:SLOT_W], slot_nxt};
  end
endmodule

// File: rtl/sqw_ctrl.sv
module sqw_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [1:0]        push_src,
  input  logic [DATA_W-1:0] push_data,
  input  logic [DATA_W-1:0] direct_value,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              push_ready,
  output logic              advance,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  import sqw_pkg::*;

  sqw_state_e state, state_nxt;
  logic       accept;
  logic       is_ind;

  assign push_ready = (state == ST_IDLE);
  assign accept     = push_valid && push_ready;
  assign is_ind     = (sqw_src_e'(push_src) == SRC_IND);

  always_comb begin
    state_nxt = state;
    advance   = 1'b0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr;
    mem_wdata = direct_value;
    if (state == ST_WBACK) begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_wdata = mem_rdata;
      advance   = 1'b1;
      state_nxt = ST_IDLE;
    end else if (accept) begin
      mem_en = 1'b1;
      if (is_ind) begin
        mem_addr  = push_data[ADDR_W-1:0];
        state_nxt = ST_WBACK;
      end else begin
        mem_we  = 1'b1;
        advance = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/sqw_queue_writer.sv
module sqw_queue_writer #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 16,
  parameter int                SLOT_W    = 6,
  parameter logic [ADDR_W-1:0] RESET_PTR = 16'h00C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [1:0]        push_src,
  input  logic [DATA_W-1:0] push_data,
  input  logic [DATA_W-1:0] bsw_in,
  input  logic [DATA_W-1:0] ttag_in,
  input  logic              ptr_wr_en,
  input  logic [ADDR_W-1:0] ptr_wr_data,
  output logic [ADDR_W-1:0] q_ptr,
  input  logic              wrap_irq_en,
  output logic              wrap_irq,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [DATA_W-1:0] direct_value;
  logic              advance;
  logic              wrap;

  sqw_value_sel #(.DATA_W(DATA_W)) u_sel (
    .src   (push_src),
    .imm   (push_data),
    .bsw   (bsw_in),
    .ttag  (ttag_in),
    .value (direct_value)
  );

  sqw_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_valid   (push_valid),
    .push_src     (push_src),
    .push_data    (push_data),
    .direct_value (direct_value),
    .ptr          (q_ptr),
    .mem_rdata    (mem_rdata),
    .push_ready   (push_ready),
    .advance      (advance),
    .mem_en       (mem_en),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata)
  );

  sqw_ptr #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .RESET_PTR(RESET_PTR)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (advance),
    .host_wr   (ptr_wr_en),
    .host_data (ptr_wr_data),
    .ptr       (q_ptr),
    .wrap      (wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) wrap_irq <= 1'b0;
    else        wrap_irq <= wrap && wrap_irq_en;
  end
endmodule

// File: rtl/sqw_checker.sv
module sqw_checker #(
  parameter int ADDR_W = 16,
  parameter int SLOT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_valid,
  input logic              push_ready,
  input logic [1:0]        push_src,
  input logic              ptr_wr_en,
  input logic [ADDR_W-1:0] ptr_wr_data,
  input logic              wrap_irq_en,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] q_ptr,
  input logic              wrap_irq
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = '1;

  logic at_last;
  assign at_last = (q_ptr[SLOT_W-1:0] == LAST_SLOT);

  a_r1_write_at_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (mem_addr == q_ptr));

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && !ptr_wr_en && !at_last) |=> (q_ptr == $past(q_ptr) + 1'b1));

  a_r4_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && !ptr_wr_en && at_last) |=>
      (q_ptr == {$past(q_ptr[ADDR_W-1:SLOT_W]), {SLOT_W{1'b0}}}));

  a_r5_irq_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && !ptr_wr_en && at_last && wrap_irq_en) |=> wrap_irq);

  a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_irq |-> $past(mem_we && at_last && wrap_irq_en && !ptr_wr_en));

  a_r6_ind_wback: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready && push_src == 2'd3) |=> (!push_ready && mem_en && mem_we));

  a_r7_host_load: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_en |=> (q_ptr == $past(ptr_wr_data)));

  a_r8_host_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && ptr_wr_en) |=> !wrap_irq);

  a_r9_idle_port: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ready && !push_valid) |-> !mem_en);
endmodule

bind sqw_queue_writer sqw_checker #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .push_valid  (push_valid),
  .push_ready  (push_ready),
  .push_src    (push_src),
  .ptr_wr_en   (ptr_wr_en),
  .ptr_wr_data (ptr_wr_data),
  .wrap_irq_en (wrap_irq_en),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .q_ptr       (q_ptr),
  .wrap_irq    (wrap_irq)
);

// File: tb/sqw_queue_writer_test.sv
`timescale 1ns/1ps
module sqw_queue_writer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic        push_ready;
  logic [1:0]  push_src = 2'd0;
  logic [15:0] push_data = '0;
  logic [15:0] bsw_in = 16'h5A01;
  logic [15:0] ttag_in = 16'h1234;
  logic        ptr_wr_en = 1'b0;
  logic [15:0] ptr_wr_data = '0;
  logic [15:0] q_ptr;
  logic        wrap_irq_en = 1'b0;
  logic        wrap_irq;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;

  logic [15:0] ram [0:4095];
  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sqw_queue_writer uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .push_src(push_src), .push_data(push_data), .bsw_in(bsw_in), .ttag_in(ttag_in),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data), .q_ptr(q_ptr),
    .wrap_irq_en(wrap_irq_en), .wrap_irq(wrap_irq), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en && mem_we) ram[mem_addr[11:0]] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= ram[mem_addr[11:0]];
    if (wrap_irq) irq_cnt <= irq_cnt + 1;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push_direct(input logic [1:0] src, input logic [15:0] d);
    @(negedge clk);
    push_valid = 1'b1; push_src = src; push_data = d;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic host_ptr(input logic [15:0] p);
    @(negedge clk);
    ptr_wr_en = 1'b1; ptr_wr_data = p;
    @(negedge clk);
    ptr_wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R2 reset ptr", q_ptr, 16'h00C0);
    check("R2 reset ready", {15'd0, push_ready}, 16'd1);
    check("R2 reset irq", {15'd0, wrap_irq}, 16'd0);
    idle(2);
    check("R9 idle port", {15'd0, mem_en}, 16'd0);
  endtask

  task automatic t_direct;
    push_direct(2'd0, 16'hA5A5);
    check("R6 direct ready stays high", {15'd0, push_ready}, 16'd1);
    push_direct(2'd1, 16'hFFFF);
    push_direct(2'd2, 16'hFFFF);
    idle(1);
    check("R1 immediate at base", ram[12'h0C0], 16'hA5A5);
    check("R1 block status", ram[12'h0C1], 16'h5A01);
    check("R1 time tag", ram[12'h0C2], 16'h1234);
    check("R3 ptr advance", q_ptr, 16'h00C3);
  endtask

  task automatic t_indirect;
    ram[12'h300] = 16'hBEEF;
    @(negedge clk);
    push_valid = 1'b1; push_src = 2'd3; push_data = 16'h0300;
    @(negedge clk);
    push_valid = 1'b0;
    check("R6 ready low in write-back", {15'd0, push_ready}, 16'd0);
    check("R6 write-back cycle", {15'd0, mem_we}, 16'd1);
    idle(2);
    check("R6 indirect data", ram[12'h0C3], 16'hBEEF);
    check("R6 ptr after indirect", q_ptr, 16'h00C4);
    check("R6 ready back", {15'd0, push_ready}, 16'd1);
  endtask

  task automatic t_wrap_irq;
    wrap_irq_en = 1'b1;
    host_ptr(16'h00FE);
    check("R7 host load", q_ptr, 16'h00FE);
    irq_cnt = 0;
    push_direct(2'd0, 16'h1111);
    idle(1);
    check("R5 no irq before last", irq_cnt[15:0], 16'd0);
    push_direct(2'd0, 16'h2222);
    idle(2);
    check("R4 wrap to base", q_ptr, 16'h00C0);
    check("R4 last slot data", ram[12'h0FF], 16'h2222);
    check("R5 one irq pulse", irq_cnt[15:0], 16'd1);
  endtask

  task automatic t_wrap_masked;
    wrap_irq_en = 1'b0;
    host_ptr(16'h00FF);
    irq_cnt = 0;
    push_direct(2'd0, 16'h3333);
    idle(2);
    check("R4 wrap masked ptr", q_ptr, 16'h00C0);
    check("R5 masked irq", irq_cnt[15:0], 16'd0);
  endtask

  task automatic t_full_lap;
    wrap_irq_en = 1'b1;
    host_ptr(16'h00D5);
    irq_cnt = 0;
    for (int i = 0; i < 64; i++) push_direct(2'd0, 16'h4000 + 16'(i));
    idle(2);
    check("R4 full lap ptr", q_ptr, 16'h00D5);
    check("R4 full lap irq", irq_cnt[15:0], 16'd1);
    check("R4 lap last word", ram[12'h0D4], 16'h403F);
  endtask

  task automatic t_relocate;
    host_ptr(16'h0400);
    push_direct(2'd0, 16'h7777);
    idle(1);
    check("R7 relocated write", ram[12'h400], 16'h7777);
    check("R7 relocated ptr", q_ptr, 16'h0401);
    wrap_irq_en = 1'b1;
    host_ptr(16'h047F);
    irq_cnt = 0;
    push_direct(2'd0, 16'h8888);
    idle(2);
    check("R4 relocated base", q_ptr, 16'h0440);
    check("R5 relocated irq", irq_cnt[15:0], 16'd1);
  endtask

  task automatic t_collision;
    wrap_irq_en = 1'b1;
    host_ptr(16'h00BF);
    irq_cnt = 0;
    @(negedge clk);
    push_valid = 1'b1; push_src = 2'd0; push_data = 16'h9999;
    ptr_wr_en = 1'b1; ptr_wr_data = 16'h0200;
    @(negedge clk);
    push_valid = 1'b0; ptr_wr_en = 1'b0;
    idle(2);
    check("R8 word at old ptr", ram[12'h0BF], 16'h9999);
    check("R8 host wins", q_ptr, 16'h0200);
    check("R8 no irq", irq_cnt[15:0], 16'd0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) ram[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_indirect();
    t_wrap_irq();
    t_wrap_masked();
    t_full_lap();
    t_relocate();
    t_collision();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule